// File: doc/BRIEF.md
# Exact-Match Forwarding Cache with Usage Aging

This block is a hardware forwarding cache for IPv4 destinations. Each entry binds one 32-bit destination address to a next-hop index. The packet path presents a destination address. Two cycles later it receives either a hit with the stored next hop, or a trap indication that sends the packet to the host CPU for a software forwarding decision. The cache starts empty. Only the host fills it: the host inserts an entry once software has resolved a route, and it deletes an entry as soon as the route changes.

Every hit marks its entry as used. The host can read an entry's usage flag, with or without clearing it, and uses that flag to keep its own software route cache alive for flows that the hardware forwards. A background aging engine starts on an external tick and visits every set. It strips the usage flag from each live entry, and it evicts any entry that was still unmarked from the previous pass. An entry that sees no traffic for two consecutive passes is therefore removed.

Storage is hashed and set-associative: 512 sets of 4 ways, 2048 entries by default. Packet lookups always take precedence. Host commands and aging steps wait while a lookup is in flight.

Top module: `route_cache`

## Requirements
- R1: A lookup whose 32-bit address equals the key of a valid entry returns rs_hit=1, rs_trap=0 and that entry's next hop. The match is exact on all address bits.
- R2: The set index is the XOR of the address cut into 9-bit slices from bit 0 upward, with the top slice zero-padded. Each set holds 4 ways.
- R3: After reset no entry is valid, so every lookup returns rs_hit=0, rs_trap=1 and next hop 0. cmd_rdy is 1 and age_busy is 0.
- R4: A lookup presented on lk_valid in one cycle has its result on rs_* with rs_valid=1 in the second cycle after it. A new lookup can be presented in every cycle.
- R5: Each lookup hit sets the usage flag of the entry it hit.
- R6: Insert (op 0) writes into the lowest-numbered free way and reports status 0 (ok). A new entry starts with its usage flag set. If the key is already present, the command reports status 1 (exists) and changes nothing. If every way of the set is valid, it reports status 2 (full) and changes nothing, so lookups for that address keep trapping.
- R7: Delete (op 1) removes a present entry and reports status 0; later lookups of that address trap. If the key is absent, delete reports status 3 (not found).
- R8: Read-and-clear (op 2) returns the usage flag on cmd_used and then clears it. Peek (op 3) returns the flag and leaves it unchanged. For an absent key, both report status 3 with cmd_used=0.
- R9: age_tick sampled while the block is idle starts a pass, and age_busy is 1 from the next cycle until the pass ends. During a pass, each valid entry with its flag set has the flag cleared, and each valid entry with its flag clear is invalidated.
- R10: A command is accepted on cmd_req with cmd_rdy=1. cmd_rdy is 1 only while idle with age_tick low. cmd_done is a one-cycle pulse carrying cmd_status. Commands and aging steps stall while a lookup occupies the first pipeline stage, so a stream of lookups delays cmd_done until one cycle after the first cycle that the stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Destination address to look up |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Result hit: forward in hardware |
| rs_trap | output | 1 | Result miss: send packet to the CPU |
| rs_nexthop | output | 12 | Next hop of the hit entry, 0 on miss |
| cmd_req | input | 1 | Host command request |
| cmd_rdy | output | 1 | Host command can be accepted |
| cmd_op | input | 2 | 0 insert, 1 delete, 2 read-and-clear usage, 3 peek usage |
| cmd_addr | input | 32 | Destination address the command acts on |
| cmd_nexthop | input | 12 | Next hop for insert |
| cmd_done | output | 1 | Command completion pulse |
| cmd_status | output | 2 | 0 ok, 1 exists, 2 full, 3 not found |
| cmd_used | output | 1 | Usage flag returned by ops 2 and 3 |
| age_tick | input | 1 | Starts an aging pass |
| age_busy | output | 1 | Aging pass in progress |

## Verification
Lookup results are due exactly two cycles after the request. The bench drives on the falling edge and samples rs_* on the second falling edge after it, including for requests issued back to back. A command's cmd_done is due one cycle after acceptance when no lookup is in flight. The bench waits for that pulse, and the priority scenario fixes the exact falling edge at which the pulse must appear after a five-cycle lookup stream. An aging pass takes one cycle per set. The bench checks age_busy one cycle after the tick, then waits for it to drop and only afterwards reads the effect through lookups.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [1:0] {
    OP_INSERT = 2'd0,
    OP_DELETE = 2'd1,
    OP_RDCLR  = 2'd2,
    OP_PEEK   = 2'd3
  } rc_op_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_EXISTS   = 2'd1,
    ST_FULL     = 2'd2,
    ST_NOTFOUND = 2'd3
  } rc_status_e;

  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_CMD  = 2'd1,
    M_AGE  = 2'd2
  } rc_mstate_e;

  // XOR-fold of a key into idx_w bits (idx_w <= 16, key_w <= 64)
  function automatic logic [15:0] rc_fold(input logic [63:0] key,
                                          input int key_w,
                                          input int idx_w);
    logic [15:0] h;
    h = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < key_w) h[i % idx_w] = h[i % idx_w] ^ key[i];
    end
    return h;
  endfunction

endpackage

// File: rtl/rc_table.sv
module rc_table #(
  parameter int SETS  = 512,
  parameter int WAYS  = 4,
  parameter int KEY_W = 32,
  parameter int NH_W  = 12,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  // lookup read port
  input  logic [IDX_W-1:0]            l_set,
  output logic [WAYS-1:0]             l_vld,
  output logic [WAYS-1:0][KEY_W-1:0]  l_key,
  output logic [WAYS-1:0][NH_W-1:0]   l_nh,
  // hit marking port
  input  logic                        h_en,
  input  logic [IDX_W-1:0]            h_set,
  input  logic [WAY_W-1:0]            h_way,
  // maintenance port
  input  logic [IDX_W-1:0]            m_set,
  output logic [WAYS-1:0]             m_vld,
  output logic [WAYS-1:0]             m_used,
  output logic [WAYS-1:0][KEY_W-1:0]  m_key,
  input  logic [WAYS-1:0]             m_we,
  input  logic [WAYS-1:0]             m_vld_wr,
  input  logic [WAYS-1:0]             m_used_wr,
  input  logic [WAYS-1:0]             m_kwe,
  input  logic [KEY_W-1:0]            m_key_wr,
  input  logic [NH_W-1:0]             m_nh_wr
);

  logic [WAYS-1:0]  vld_q  [SETS];
  logic [WAYS-1:0]  used_q [SETS];
  logic [WAYS-1:0]  vld_d  [SETS];
  logic [WAYS-1:0]  used_d [SETS];
  logic [KEY_W-1:0] key_q  [SETS][WAYS];
  logic [NH_W-1:0]  nh_q   [SETS][WAYS];
  logic             flag_en;

  assign flag_en = h_en | (|m_we);

  always_comb begin
    vld_d  = vld_q;
    used_d = used_q;
    for (int w = 0; w < WAYS; w++) begin
      if (m_we[w]) begin
        vld_d[m_set][w]  = m_vld_wr[w];
        used_d[m_set][w] = m_used_wr[w];
      end
    end
    if (h_en) used_d[h_set][h_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        used_q[s] <= '0;
      end
    end else if (flag_en) begin
      vld_q  <= vld_d;
      used_q <= used_d;
    end
  end

  // key and next hop carry no reset: qualified by the valid flags
  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (m_kwe[w]) begin
        key_q[m_set][w] <= m_key_wr;
        nh_q[m_set][w]  <= m_nh_wr;
      end
    end
  end

  assign l_vld  = vld_q[l_set];
  assign m_vld  = vld_q[m_set];
  assign m_used = used_q[m_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign l_key[w] = key_q[l_set][w];
    assign l_nh[w]  = nh_q[l_set][w];
    assign m_key[w] = key_q[m_set][w];
  end

  // R10: maintenance never writes in a cycle where a hit is marked
  p_single_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    h_en |-> (m_we == '0));

endmodule

// File: rtl/rc_lookup.sv
module rc_lookup
  import rc_pkg::*;
#(
  parameter int SETS  = 512,
  parameter int WAYS  = 4,
  parameter int KEY_W = 32,
  parameter int NH_W  = 12,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_valid,
  input  logic [KEY_W-1:0]            lk_addr,
  output logic                        s1_busy,
  output logic [IDX_W-1:0]            t_set,
  input  logic [WAYS-1:0]             t_vld,
  input  logic [WAYS-1:0][KEY_W-1:0]  t_key,
  input  logic [WAYS-1:0][NH_W-1:0]   t_nh,
  output logic                        h_en,
  output logic [IDX_W-1:0]            h_set,
  output logic [WAY_W-1:0]            h_way,
  output logic                        rs_valid,
  output logic                        rs_hit,
  output logic                        rs_trap,
  output logic [NH_W-1:0]             rs_nexthop
);

  logic             s1_vld_q, s1_vld_d;
  logic [KEY_W-1:0] s1_addr_q;
  logic [WAYS-1:0]  match;
  logic             hit;
  logic [WAY_W-1:0] way_sel;
  logic [NH_W-1:0]  nh_sel;
  logic             rv_q, rh_q, rv_d, rh_d;
  logic [NH_W-1:0]  rn_q, rn_d;

  // stage 1: capture request
  assign s1_vld_d = lk_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld_q <= 1'b0;
    else        s1_vld_q <= s1_vld_d;
  end

  always_ff @(posedge clk) begin
    if (lk_valid) s1_addr_q <= lk_addr;
  end

  assign t_set   = IDX_W'(rc_fold(64'(s1_addr_q), KEY_W, IDX_W));
  assign s1_busy = s1_vld_q;

  // stage 2: compare all ways of the set
  always_comb begin
    way_sel = '0;
    nh_sel  = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w] = t_vld[w] && (t_key[w] == s1_addr_q);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        way_sel = WAY_W'(w);
        nh_sel  = t_nh[w];
      end
    end
    hit = |match;
  end

  assign h_en  = s1_vld_q & hit;
  assign h_set = t_set;
  assign h_way = way_sel;

  always_comb begin
    rv_d = s1_vld_q;
    rh_d = s1_vld_q & hit;
    rn_d = hit ? nh_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      rn_q <= '0;
    end else begin
      rv_q <= rv_d;
      rh_q <= rh_d;
      if (s1_vld_q) rn_q <= rn_d;
    end
  end

  assign rs_valid   = rv_q;
  assign rs_hit     = rh_q;
  assign rs_trap    = rv_q & ~rh_q;
  assign rs_nexthop = rn_q;

  // R6: inserts never duplicate a key, so at most one way matches
  p_unique_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_q |-> $onehot0(match));

  // R4: fixed two-cycle result latency
  p_latency_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> ##1 rs_valid);

endmodule

// File: rtl/rc_maint.sv
module rc_maint
  import rc_pkg::*;
#(
  parameter int SETS  = 512,
  parameter int WAYS  = 4,
  parameter int KEY_W = 32,
  parameter int NH_W  = 12,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s1_busy,
  input  logic                        cmd_req,
  output logic                        cmd_rdy,
  input  logic [1:0]                  cmd_op,
  input  logic [KEY_W-1:0]            cmd_addr,
  input  logic [NH_W-1:0]             cmd_nexthop,
  output logic                        cmd_done,
  output logic [1:0]                  cmd_status,
  output logic                        cmd_used,
  input  logic                        age_tick,
  output logic                        age_busy,
  output logic [IDX_W-1:0]            m_set,
  input  logic [WAYS-1:0]             m_vld,
  input  logic [WAYS-1:0]             m_used,
  input  logic [WAYS-1:0][KEY_W-1:0]  m_key,
  output logic [WAYS-1:0]             m_we,
  output logic [WAYS-1:0]             m_vld_wr,
  output logic [WAYS-1:0]             m_used_wr,
  output logic [WAYS-1:0]             m_kwe,
  output logic [KEY_W-1:0]            m_key_wr,
  output logic [NH_W-1:0]             m_nh_wr
);

  rc_mstate_e       st_q, st_d;
  rc_op_e           op_q;
  logic [KEY_W-1:0] addr_q;
  logic [NH_W-1:0]  nh_q;
  logic [IDX_W-1:0] cset_q;
  logic [IDX_W-1:0] aset_q, aset_d;
  logic             done_q, done_d;
  rc_status_e       stat_q, stat_d;
  logic             used_q, used_d;
  logic             accept;
  logic [WAYS-1:0]  mt;
  logic             found, free;
  logic [WAY_W-1:0] mway, fway;

  assign cmd_rdy = (st_q == M_IDLE) && !age_tick;
  assign accept  = cmd_req && cmd_rdy;
  assign m_set   = (st_q == M_AGE) ? aset_q : cset_q;

  // locate the key and the lowest free way in the addressed set
  always_comb begin
    mway = '0;
    fway = '0;
    for (int w = 0; w < WAYS; w++) mt[w] = m_vld[w] && (m_key[w] == addr_q);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (mt[w])     mway = WAY_W'(w);
      if (!m_vld[w]) fway = WAY_W'(w);
    end
    found = |mt;
    free  = ~&m_vld;
  end

  assign m_key_wr = addr_q;
  assign m_nh_wr  = nh_q;

  always_comb begin
    st_d      = st_q;
    aset_d    = aset_q;
    done_d    = 1'b0;
    stat_d    = stat_q;
    used_d    = used_q;
    m_we      = '0;
    m_vld_wr  = '0;
    m_used_wr = '0;
    m_kwe     = '0;
    case (st_q)
      M_IDLE: begin
        if (age_tick) begin
          st_d   = M_AGE;
          aset_d = '0;
        end else if (accept) begin
          st_d = M_CMD;
        end
      end
      M_CMD: begin
        if (!s1_busy) begin
          st_d   = M_IDLE;
          done_d = 1'b1;
          used_d = 1'b0;
          case (op_q)
            OP_INSERT: begin
              if (found)      stat_d = ST_EXISTS;
              else if (!free) stat_d = ST_FULL;
              else begin
                stat_d          = ST_OK;
                m_we[fway]      = 1'b1;
                m_vld_wr[fway]  = 1'b1;
                m_used_wr[fway] = 1'b1;
                m_kwe[fway]     = 1'b1;
              end
            end
            OP_DELETE: begin
              if (found) begin
                stat_d     = ST_OK;
                m_we[mway] = 1'b1;
              end else begin
                stat_d = ST_NOTFOUND;
              end
            end
            default: begin
              if (found) begin
                stat_d = ST_OK;
                used_d = m_used[mway];
                if (op_q == OP_RDCLR) begin
                  m_we[mway]     = 1'b1;
                  m_vld_wr[mway] = 1'b1;
                end
              end else begin
                stat_d = ST_NOTFOUND;
              end
            end
          endcase
        end
      end
      M_AGE: begin
        if (!s1_busy) begin
          m_we     = m_vld;
          m_vld_wr = m_used;
          if (aset_q == IDX_W'(SETS - 1)) st_d = M_IDLE;
          else                            aset_d = aset_q + 1'b1;
        end
      end
      default: st_d = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= M_IDLE;
      aset_q <= '0;
      done_q <= 1'b0;
      stat_q <= ST_OK;
      used_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      aset_q <= aset_d;
      done_q <= done_d;
      stat_q <= stat_d;
      used_q <= used_d;
    end
  end

  // command fields latched on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_INSERT;
      addr_q <= '0;
      nh_q   <= '0;
      cset_q <= '0;
    end else if (accept) begin
      op_q   <= rc_op_e'(cmd_op);
      addr_q <= cmd_addr;
      nh_q   <= cmd_nexthop;
      cset_q <= IDX_W'(rc_fold(64'(cmd_addr), KEY_W, IDX_W));
    end
  end

  assign cmd_done   = done_q;
  assign cmd_status = stat_q;
  assign cmd_used   = used_q;
  assign age_busy   = (st_q == M_AGE);

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  // R10: an accepted command closes the handshake for the next cycle
  p_accept_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_rdy) |=> !cmd_rdy);

  // R9: a tick seen while idle starts a pass
  p_tick_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_tick && !age_busy && !cmd_done && (st_q == M_IDLE)) |=> age_busy);

endmodule

// File: rtl/route_cache.sv
module route_cache #(
  parameter int SETS  = 512,
  parameter int WAYS  = 4,
  parameter int KEY_W = 32,
  parameter int NH_W  = 12,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [KEY_W-1:0] lk_addr,
  output logic             rs_valid,
  output logic             rs_hit,
  output logic             rs_trap,
  output logic [NH_W-1:0]  rs_nexthop,
  input  logic             cmd_req,
  output logic             cmd_rdy,
  input  logic [1:0]       cmd_op,
  input  logic [KEY_W-1:0] cmd_addr,
  input  logic [NH_W-1:0]  cmd_nexthop,
  output logic             cmd_done,
  output logic [1:0]       cmd_status,
  output logic             cmd_used,
  input  logic             age_tick,
  output logic             age_busy
);

  logic                       s1_busy;
  logic [IDX_W-1:0]           l_set, h_set, m_set;
  logic [WAYS-1:0]            l_vld, m_vld, m_used;
  logic [WAYS-1:0][KEY_W-1:0] l_key, m_key;
  logic [WAYS-1:0][NH_W-1:0]  l_nh;
  logic                       h_en;
  logic [WAY_W-1:0]           h_way;
  logic [WAYS-1:0]            m_we, m_vld_wr, m_used_wr, m_kwe;
  logic [KEY_W-1:0]           m_key_wr;
  logic [NH_W-1:0]            m_nh_wr;

  rc_lookup #(.SETS(SETS), .WAYS(WAYS), .KEY_W(KEY_W), .NH_W(NH_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .s1_busy(s1_busy), .t_set(l_set), .t_vld(l_vld), .t_key(l_key), .t_nh(l_nh),
    .h_en(h_en), .h_set(h_set), .h_way(h_way),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_trap(rs_trap), .rs_nexthop(rs_nexthop)
  );

  rc_maint #(.SETS(SETS), .WAYS(WAYS), .KEY_W(KEY_W), .NH_W(NH_W)) u_maint (
    .clk(clk), .rst_n(rst_n), .s1_busy(s1_busy),
    .cmd_req(cmd_req), .cmd_rdy(cmd_rdy), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_nexthop(cmd_nexthop), .cmd_done(cmd_done), .cmd_status(cmd_status),
    .cmd_used(cmd_used), .age_tick(age_tick), .age_busy(age_busy),
    .m_set(m_set), .m_vld(m_vld), .m_used(m_used), .m_key(m_key),
    .m_we(m_we), .m_vld_wr(m_vld_wr), .m_used_wr(m_used_wr), .m_kwe(m_kwe),
    .m_key_wr(m_key_wr), .m_nh_wr(m_nh_wr)
  );

  rc_table #(.SETS(SETS), .WAYS(WAYS), .KEY_W(KEY_W), .NH_W(NH_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .l_set(l_set), .l_vld(l_vld), .l_key(l_key), .l_nh(l_nh),
    .h_en(h_en), .h_set(h_set), .h_way(h_way),
    .m_set(m_set), .m_vld(m_vld), .m_used(m_used), .m_key(m_key),
    .m_we(m_we), .m_vld_wr(m_vld_wr), .m_used_wr(m_used_wr), .m_kwe(m_kwe),
    .m_key_wr(m_key_wr), .m_nh_wr(m_nh_wr)
  );

  // R3: a result is never both forwarded and trapped
  p_hit_trap_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> (rs_hit ^ rs_trap));

endmodule

// File: tb/test_route_cache.sv
module test_route_cache;

  localparam int NH_W = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            lk_valid;
  logic [31:0]     lk_addr;
  logic            rs_valid, rs_hit, rs_trap;
  logic [NH_W-1:0] rs_nexthop;
  logic            cmd_req, cmd_rdy;
  logic [1:0]      cmd_op;
  logic [31:0]     cmd_addr;
  logic [NH_W-1:0] cmd_nexthop;
  logic            cmd_done;
  logic [1:0]      cmd_status;
  logic            cmd_used;
  logic            age_tick, age_busy;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  route_cache i_route_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_trap(rs_trap), .rs_nexthop(rs_nexthop),
    .cmd_req(cmd_req), .cmd_rdy(cmd_rdy), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_nexthop(cmd_nexthop), .cmd_done(cmd_done), .cmd_status(cmd_status),
    .cmd_used(cmd_used), .age_tick(age_tick), .age_busy(age_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // set index model: XOR of 9-bit slices, top slice zero-padded (R2)
  function automatic logic [8:0] set_of(input logic [31:0] a);
    return a[8:0] ^ a[17:9] ^ a[26:18] ^ {4'b0, a[31:27]};
  endfunction

  // one lookup, result sampled on the second falling edge (R4)
  task automatic lookup(input logic [31:0] a, output logic v, output logic h,
                        output logic t, output logic [NH_W-1:0] n);
    lk_valid = 1'b1;
    lk_addr  = a;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    v = rs_valid; h = rs_hit; t = rs_trap; n = rs_nexthop;
  endtask

  task automatic expect_hit(input string req, input logic [31:0] a, input logic [NH_W-1:0] nh);
    logic v, h, t;
    logic [NH_W-1:0] n;
    lookup(a, v, h, t, n);
    chk({req, " hit"}, {29'd0, v, h, t}, 32'b110);
    chk({req, " nexthop"}, 32'(n), 32'(nh));
  endtask

  task automatic expect_trap(input string req, input logic [31:0] a);
    logic v, h, t;
    logic [NH_W-1:0] n;
    lookup(a, v, h, t, n);
    chk({req, " trap"}, {29'd0, v, h, t}, 32'b101);
  endtask

  task automatic command(input logic [1:0] op, input logic [31:0] a, input logic [NH_W-1:0] nh,
                         output logic [1:0] st, output logic u);
    while (!cmd_rdy) @(negedge clk);
    cmd_req = 1'b1; cmd_op = op; cmd_addr = a; cmd_nexthop = nh;
    @(negedge clk);
    cmd_req = 1'b0;
    while (!cmd_done) @(negedge clk);
    st = cmd_status; u = cmd_used;
  endtask

  task automatic expect_cmd(input string req, input logic [1:0] op, input logic [31:0] a,
                            input logic [NH_W-1:0] nh, input logic [1:0] exp_st);
    logic [1:0] st;
    logic u;
    command(op, a, nh, st, u);
    chk({req, " status"}, 32'(st), 32'(exp_st));
  endtask

  task automatic expect_usage(input string req, input logic [1:0] op, input logic [31:0] a,
                              input logic exp_u);
    logic [1:0] st;
    logic u;
    command(op, a, '0, st, u);
    chk({req, " usage status"}, 32'(st), 32'd0);
    chk({req, " usage flag"}, 32'(u), 32'(exp_u));
  endtask

  task automatic age_pass(input string req);
    age_tick = 1'b1;
    @(negedge clk);
    age_tick = 1'b0;
    chk({req, " busy after tick"}, 32'(age_busy), 32'd1);
    chk({req, " rdy low while aging"}, 32'(cmd_rdy), 32'd0);
    while (age_busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3 cmd_rdy after reset", 32'(cmd_rdy), 32'd1);
    chk("R3 age_busy after reset", 32'(age_busy), 32'd0);
    expect_trap("R3 empty table", 32'h0A00_0001);
    expect_trap("R3 empty table", 32'hC0A8_0101);
  endtask

  task automatic t_insert_hit();
    expect_cmd("R6 insert", 2'd0, 32'h0A00_0001, 12'h123, 2'd0);
    expect_hit("R1 R4 lookup", 32'h0A00_0001, 12'h123);
    expect_trap("R1 exact match neighbour", 32'h0A00_0002);
    expect_trap("R1 exact match high bit", 32'h8A00_0001);
  endtask

  task automatic t_pipeline();
    expect_cmd("R6 insert", 2'd0, 32'h0A00_0010, 12'h0B1, 2'd0);
    lk_valid = 1'b1; lk_addr = 32'h0A00_0010;
    @(negedge clk);
    lk_addr = 32'h0A00_0011;
    @(negedge clk);
    chk("R4 back-to-back 1st", {20'd0, rs_valid, rs_hit, rs_nexthop[9:0]}, {20'd0, 2'b11, 10'h0B1});
    lk_addr = 32'h0A00_0001;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R4 back-to-back 2nd", {29'd0, rs_valid, rs_hit, rs_trap}, 32'b101);
    @(negedge clk);
    chk("R4 back-to-back 3rd", {20'd0, rs_valid, rs_hit, rs_nexthop[9:0]}, {20'd0, 2'b11, 10'h123});
    @(negedge clk);
    chk("R4 no request no result", 32'(rs_valid), 32'd0);
  endtask

  task automatic t_duplicate();
    expect_cmd("R6 duplicate", 2'd0, 32'h0A00_0001, 12'h777, 2'd1);
    expect_hit("R6 duplicate unchanged", 32'h0A00_0001, 12'h123);
  endtask

  task automatic t_full_set();
    logic [8:0] s;
    s = 9'h055;
    for (int k = 1; k <= 4; k++) begin
      logic [31:0] a;
      a = {5'd0, 9'(k), 9'(k), s};
      chk("R2 set model", 32'(set_of(a)), 32'(s));
      expect_cmd("R6 fill set", 2'd0, a, 12'(k), 2'd0);
    end
    expect_cmd("R6 set full", 2'd0, {5'd0, 9'd5, 9'd5, s}, 12'h055, 2'd2);
    expect_trap("R6 refused keeps trapping", {5'd0, 9'd5, 9'd5, s});
    for (int k = 1; k <= 4; k++) begin
      expect_hit("R2 four ways", {5'd0, 9'(k), 9'(k), s}, 12'(k));
    end
  endtask

  task automatic t_delete();
    logic [31:0] a;
    a = {5'd0, 9'd2, 9'd2, 9'h055};
    expect_cmd("R7 delete", 2'd1, a, '0, 2'd0);
    expect_trap("R7 deleted traps", a);
    expect_cmd("R7 delete absent", 2'd1, a, '0, 2'd3);
    expect_cmd("R6 reuse freed way", 2'd0, {5'd0, 9'd5, 9'd5, 9'h055}, 12'h0E5, 2'd0);
    expect_hit("R6 reuse freed way", {5'd0, 9'd5, 9'd5, 9'h055}, 12'h0E5);
  endtask

  task automatic t_usage();
    logic [1:0] st;
    logic u;
    expect_cmd("R6 insert", 2'd0, 32'hC0A8_0101, 12'h201, 2'd0);
    expect_usage("R6 fresh entry used", 2'd3, 32'hC0A8_0101, 1'b1);
    expect_usage("R8 read-and-clear", 2'd2, 32'hC0A8_0101, 1'b1);
    expect_usage("R8 cleared", 2'd3, 32'hC0A8_0101, 1'b0);
    expect_usage("R8 peek keeps", 2'd3, 32'hC0A8_0101, 1'b0);
    expect_hit("R5 lookup", 32'hC0A8_0101, 12'h201);
    expect_usage("R5 hit marks used", 2'd2, 32'hC0A8_0101, 1'b1);
    command(2'd2, 32'hC0A8_0999, '0, st, u);
    chk("R8 absent status", 32'(st), 32'd3);
    chk("R8 absent flag", 32'(u), 32'd0);
  endtask

  task automatic t_priority();
    cmd_req = 1'b1; cmd_op = 2'd0; cmd_addr = 32'h0AAA_0001; cmd_nexthop = 12'h3C3;
    lk_valid = 1'b1; lk_addr = 32'h0BBB_0001;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i == 1) cmd_req = 1'b0;
      if (i == 5) lk_valid = 1'b0;
      chk("R10 stalled by lookups", 32'(cmd_done), 32'd0);
    end
    @(negedge clk);
    chk("R10 stalled until stage empty", 32'(cmd_done), 32'd0);
    @(negedge clk);
    chk("R10 done after stall", {30'd0, cmd_done, cmd_status == 2'd0}, 32'b11);
    @(negedge clk);
    chk("R10 done is a pulse", 32'(cmd_done), 32'd0);
    expect_hit("R10 stalled insert landed", 32'h0AAA_0001, 12'h3C3);
  endtask

  task automatic t_aging();
    expect_cmd("R6 insert", 2'd0, 32'h1111_0001, 12'h0A1, 2'd0);
    expect_cmd("R6 insert", 2'd0, 32'h2222_0002, 12'h0A2, 2'd0);
    age_pass("R9 pass 1");
    expect_usage("R9 pass clears flag", 2'd3, 32'h2222_0002, 1'b0);
    expect_hit("R9 survives one pass", 32'h2222_0002, 12'h0A2);
    expect_usage("R8 drop hit mark", 2'd2, 32'h2222_0002, 1'b1);
    expect_hit("R5 refresh", 32'h1111_0001, 12'h0A1);
    age_pass("R9 pass 2");
    expect_hit("R9 used entry kept", 32'h1111_0001, 12'h0A1);
    expect_trap("R9 idle entry evicted", 32'h2222_0002);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0; cmd_req = 1'b0; cmd_op = '0;
    cmd_addr = '0; cmd_nexthop = '0; age_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_insert_hit();
    t_pipeline();
    t_duplicate();
    t_full_set();
    t_delete();
    t_usage();
    t_priority();
    t_aging();
    report();
    $finish;
  end

endmodule